// File: doc/BRIEF.md
# Direct-Mapped Cache Store Controller

This block takes CPU stores aimed at a direct-mapped data cache and decides, per store, whether to update the cache, write external memory, allocate a line, or evict a victim. The cache holds `LINES` lines of `LINE_BYTES` bytes; with the defaults (512 lines of 32 bytes) the line index is address bits [13:5] and the byte offset inside the line is bits [4:0]. The tag is every address bit above the index. Tag, valid, dirty and data storage sit inside the block.

A mode pin selects copy-back or write-through, and it is sampled when a store is accepted. In copy-back mode a miss writes the store into the indexed line at once, then asks for a line fill. The returned line fills every byte the store did not write. If the old line was valid and dirty, its tag and data are first captured in a write-back buffer. That buffer goes out to external memory only after the fill has completed. In write-through mode a hit updates the line and also writes memory, and a miss writes only memory.

The store port, the external write port, the fill request and the fill return all use valid/ready. A source holds valid and its payload steady until ready is seen high at a clock edge. The block accepts a store only when idle (`st_ready` high) and stalls the store port while any fill or memory write is outstanding. External-write and fill-request payloads stay stable while their ready is low. The fill return is taken only while `fd_ready` is high.

Top module: `wcache_store_ctrl`

## Requirements
- R1: A store of size code 0 (byte), 1 (word, 2 bytes), 2 (longword, 4 bytes) or 3 (quadword, 8 bytes) writes exactly that many bytes of the cache line. The bytes are taken from the low bytes of `st_data`, little-endian, starting at line byte `st_addr[4:0]`, into the line indexed by `st_addr[13:5]`.
- R2: A copy-back hit updates the line, marks it dirty, issues no external write and no fill request, and leaves the block idle.
- R3: A write-through hit updates the line and issues one external write. That write carries the store's address, its size code (0..3) and `st_data` in the low bytes of `ew_data`, with all other bits zero.
- R4: A write-through miss issues only the external write described in R3. It issues no fill, and the cache is unchanged, so a later copy-back store to that address still misses.
- R5: A copy-back miss requests a fill at the store address with bits [1:0] cleared. When the victim is invalid or clean, no external write follows.
- R6: When the fill data arrives, bytes written by the store keep the store's value and all other bytes take the fill data. The line then holds the new tag and is both valid and dirty.
- R7: A copy-back miss on a valid dirty victim writes the victim back only after the fill has completed. The write uses size code 4 (whole line), the victim's line-aligned address (its tag and the index) and the victim's data as it was before the new store.
- R8: A word store with `st_addr[0]`=1, a longword with `st_addr[1:0]`≠0, or a quadword with `st_addr[2:0]`≠0 is accepted but ignored. `st_err` is high for one cycle, in the cycle after acceptance, and no cache state, fill or external write results.
- R9: From the acceptance of a store that needs a fill or an external write until that work ends, `busy` is 1 and `st_ready` is 0. `fr_valid`/`fr_addr` and `ew_valid`/`ew_addr`/`ew_size` hold steady while their ready is low.
- R10: After reset every line is invalid, `busy` is 0, `st_ready` is 1, and neither `ew_valid` nor `fr_valid` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wt | input | 1 | 1 = write-through, 0 = copy-back |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store request accepted at this edge when valid |
| st_addr | input | AW | Store byte address |
| st_size | input | 2 | 0 byte, 1 word, 2 longword, 3 quadword |
| st_data | input | 64 | Store data, low bytes used |
| st_err | output | 1 | One-cycle misalignment flag |
| busy | output | 1 | Fill or memory write outstanding |
| ew_valid | output | 1 | External write valid |
| ew_ready | input | 1 | External write accepted |
| ew_addr | output | AW | External write address |
| ew_size | output | 3 | 0..3 as st_size, 4 = whole line |
| ew_data | output | 8*LINE_BYTES | External write data, low-aligned |
| fr_valid | output | 1 | Fill request valid |
| fr_ready | input | 1 | Fill request accepted |
| fr_addr | output | AW | Fill start address (longword aligned) |
| fd_valid | input | 1 | Fill line data valid |
| fd_ready | output | 1 | Block waiting for fill data |
| fd_data | input | 8*LINE_BYTES | Whole line of fill data |

## Verification
The hardest case to reach is the dirty-victim path. The ports give no read access, so line contents and dirty state can only be seen when a later miss on the same index evicts the line. The stimulus builds each line in stages: a fill, a hit, a write-through hit and rejected misaligned stores, all on one index. It then forces an eviction with a new tag and compares the written-back line byte for byte. The bench also holds the fill return back for several cycles and confirms that no write-back leaves early.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  typedef enum logic [1:0] {SZ_BYTE, SZ_WORD, SZ_LONG, SZ_QUAD} st_size_e;
  typedef enum logic [2:0] {W_IDLE, W_EXT, W_FREQ, W_FWAIT, W_WB} wcs_state_e;
  localparam logic [2:0] EW_LINE = 3'd4;
endpackage

// File: rtl/wcs_steer.sv
module wcs_steer import wcs_pkg::*; #(
  parameter int LINE_BYTES = 32
) (
  input  logic [1:0]                  size,
  input  logic [$clog2(LINE_BYTES)-1:0] off,
  input  logic [63:0]                 data,
  output logic [LINE_BYTES-1:0]       mask,
  output logic [8*LINE_BYTES-1:0]     line,
  output logic                        misal
);
  localparam int LINE_BITS = 8 * LINE_BYTES;
  logic [LINE_BYTES-1:0] base;

  always_comb begin
    unique case (st_size_e'(size))
      SZ_BYTE: begin base = LINE_BYTES'(8'h01); misal = 1'b0;         end
      SZ_WORD: begin base = LINE_BYTES'(8'h03); misal = off[0];       end
      SZ_LONG: begin base = LINE_BYTES'(8'h0F); misal = |off[1:0];    end
      default: begin base = LINE_BYTES'(8'hFF); misal = |off[2:0];    end
    endcase
  end

  assign mask = base << off;
  assign line = LINE_BITS'(data) << {off, 3'b000};
endmodule

// File: rtl/wcs_array.sv
module wcs_array #(
  parameter int LINES      = 512,
  parameter int LINE_BYTES = 32,
  parameter int TAG_W      = 18
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(LINES)-1:0]   rd_idx,
  output logic [TAG_W-1:0]           rd_tag,
  output logic                       rd_valid,
  output logic                       rd_dirty,
  output logic [8*LINE_BYTES-1:0]    rd_data,
  input  logic [$clog2(LINES)-1:0]   wr_idx,
  input  logic                       wr_en,
  input  logic [LINE_BYTES-1:0]      wr_mask,
  input  logic [8*LINE_BYTES-1:0]    wr_data,
  input  logic                       meta_en,
  input  logic [TAG_W-1:0]           meta_tag,
  input  logic                       meta_valid,
  input  logic                       meta_dirty
);
  localparam int LINE_BITS = 8 * LINE_BYTES;

  logic [LINE_BITS-1:0] data_mem [LINES];
  logic [TAG_W-1:0]     tag_mem  [LINES];
  logic [LINES-1:0]     valid_q, dirty_q;

  assign rd_tag   = tag_mem[rd_idx];
  assign rd_data  = data_mem[rd_idx];
  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];

  always_ff @(posedge clk) begin
    if (wr_en)
      for (int b = 0; b < LINE_BYTES; b++)
        if (wr_mask[b]) data_mem[wr_idx][8*b +: 8] <= wr_data[8*b +: 8];
    if (meta_en) tag_mem[wr_idx] <= meta_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (meta_en) begin
      valid_q[wr_idx] <= meta_valid;
      dirty_q[wr_idx] <= meta_dirty;
    end
  end
endmodule

// File: rtl/wcache_store_ctrl.sv
module wcache_store_ctrl import wcs_pkg::*; #(
  parameter int AW         = 32,
  parameter int LINES      = 512,
  parameter int LINE_BYTES = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_wt,
  input  logic                    st_valid,
  output logic                    st_ready,
  input  logic [AW-1:0]           st_addr,
  input  logic [1:0]              st_size,
  input  logic [63:0]             st_data,
  output logic                    st_err,
  output logic                    busy,
  output logic                    ew_valid,
  input  logic                    ew_ready,
  output logic [AW-1:0]           ew_addr,
  output logic [2:0]              ew_size,
  output logic [8*LINE_BYTES-1:0] ew_data,
  output logic                    fr_valid,
  input  logic                    fr_ready,
  output logic [AW-1:0]           fr_addr,
  input  logic                    fd_valid,
  output logic                    fd_ready,
  input  logic [8*LINE_BYTES-1:0] fd_data
);
  localparam int OFF_W     = $clog2(LINE_BYTES);
  localparam int IDX_W     = $clog2(LINES);
  localparam int TAG_W     = AW - OFF_W - IDX_W;
  localparam int LINE_BITS = 8 * LINE_BYTES;

  wcs_state_e state_q, state_d;
  logic [AW-1:0]         req_addr_q;
  logic [1:0]            req_size_q;
  logic [63:0]           req_raw_q;
  logic [LINE_BYTES-1:0] req_mask_q;
  logic [TAG_W-1:0]      wb_tag_q;
  logic [LINE_BITS-1:0]  wb_data_q;
  logic                  wb_pend_q, err_q;

  logic [TAG_W-1:0]      st_tag, req_tag, rd_tag, meta_tag;
  logic [IDX_W-1:0]      st_idx, req_idx, rd_idx, wr_idx;
  logic [LINE_BYTES-1:0] st_mask, wr_mask;
  logic [LINE_BITS-1:0]  st_line, rd_data, wr_data;
  logic st_misal, rd_valid, rd_dirty, hit, accept, good;
  logic wr_en, meta_en, meta_valid, meta_dirty;

  assign st_tag  = st_addr[AW-1 -: TAG_W];
  assign st_idx  = st_addr[OFF_W +: IDX_W];
  assign req_tag = req_addr_q[AW-1 -: TAG_W];
  assign req_idx = req_addr_q[OFF_W +: IDX_W];

  wcs_steer #(.LINE_BYTES(LINE_BYTES)) u_steer (
    .size(st_size), .off(st_addr[OFF_W-1:0]), .data(st_data),
    .mask(st_mask), .line(st_line), .misal(st_misal)
  );

  assign rd_idx = (state_q == W_IDLE) ? st_idx : req_idx;

  wcs_array #(.LINES(LINES), .LINE_BYTES(LINE_BYTES), .TAG_W(TAG_W)) u_array (
    .clk, .rst_n, .rd_idx, .rd_tag, .rd_valid, .rd_dirty, .rd_data,
    .wr_idx, .wr_en, .wr_mask, .wr_data,
    .meta_en, .meta_tag, .meta_valid, .meta_dirty
  );

  assign st_ready = (state_q == W_IDLE);
  assign accept   = st_valid && st_ready;
  assign good     = accept && !st_misal;
  assign hit      = rd_valid && (rd_tag == st_tag);

  always_comb begin
    state_d    = state_q;
    wr_idx     = rd_idx;
    wr_en      = 1'b0;
    wr_mask    = st_mask;
    wr_data    = st_line;
    meta_en    = 1'b0;
    meta_tag   = st_tag;
    meta_valid = 1'b1;
    meta_dirty = 1'b1;
    unique case (state_q)
      W_IDLE: if (good) begin
        if (mode_wt) begin
          wr_en      = hit;
          state_d    = W_EXT;
        end else begin
          wr_en      = 1'b1;
          meta_en    = 1'b1;
          meta_valid = hit;
          meta_dirty = hit;
          meta_tag   = hit ? rd_tag : st_tag;
          state_d    = hit ? W_IDLE : W_FREQ;
        end
      end
      W_EXT:   if (ew_ready) state_d = W_IDLE;
      W_FREQ:  if (fr_ready) state_d = W_FWAIT;
      W_FWAIT: if (fd_valid) begin
        wr_en    = 1'b1;
        wr_mask  = ~req_mask_q;
        wr_data  = fd_data;
        meta_en  = 1'b1;
        meta_tag = req_tag;
        state_d  = wb_pend_q ? W_WB : W_IDLE;
      end
      W_WB:    if (ew_ready) state_d = W_IDLE;
      default: state_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= W_IDLE;
      req_addr_q <= '0;
      req_size_q <= '0;
      req_raw_q  <= '0;
      req_mask_q <= '0;
      wb_tag_q   <= '0;
      wb_data_q  <= '0;
      wb_pend_q  <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= accept && st_misal;
      if (good) begin
        req_addr_q <= st_addr;
        req_size_q <= st_size;
        req_raw_q  <= st_data;
        req_mask_q <= st_mask;
        wb_pend_q  <= !mode_wt && !hit && rd_valid && rd_dirty;
        wb_tag_q   <= rd_tag;
        wb_data_q  <= rd_data;
      end
    end
  end

  assign st_err   = err_q;
  assign busy     = (state_q != W_IDLE);
  assign fr_valid = (state_q == W_FREQ);
  assign fr_addr  = {req_addr_q[AW-1:2], 2'b00};
  assign fd_ready = (state_q == W_FWAIT);
  assign ew_valid = (state_q == W_EXT) || (state_q == W_WB);
  assign ew_addr  = (state_q == W_WB) ? {wb_tag_q, req_idx, {OFF_W{1'b0}}} : req_addr_q;
  assign ew_size  = (state_q == W_WB) ? EW_LINE : {1'b0, req_size_q};
  assign ew_data  = (state_q == W_WB) ? wb_data_q : LINE_BITS'(req_raw_q);
endmodule

// File: rtl/wcs_chk.sv
module wcs_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_valid,
  input logic          st_ready,
  input logic          st_err,
  input logic          busy,
  input logic          fr_valid,
  input logic          fr_ready,
  input logic [AW-1:0] fr_addr,
  input logic          ew_valid,
  input logic          ew_ready,
  input logic [AW-1:0] ew_addr,
  input logic [2:0]    ew_size,
  input logic          fd_valid,
  input logic          fd_ready
);
  // R9
  fr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fr_valid && !fr_ready |=> fr_valid && $stable(fr_addr));

  // R9
  ew_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ew_valid && !ew_ready |=> ew_valid && $stable(ew_addr) && $stable(ew_size));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(st_valid && st_ready));

  // R7
  wb_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ew_valid) && (ew_size == 3'd4) |-> $past(fd_valid && fd_ready));

  // R8
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_err |-> $past(st_valid && st_ready) && !busy);

  // R9
  one_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fr_valid && ew_valid));
endmodule

bind wcache_store_ctrl wcs_chk #(.AW(AW)) u_wcs_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
  .st_err(st_err), .busy(busy), .fr_valid(fr_valid), .fr_ready(fr_ready),
  .fr_addr(fr_addr), .ew_valid(ew_valid), .ew_ready(ew_ready),
  .ew_addr(ew_addr), .ew_size(ew_size), .fd_valid(fd_valid), .fd_ready(fd_ready)
);

// File: tb/test_wcache_store_ctrl.sv
module test_wcache_store_ctrl;
  logic clk = 0, rst_n = 0, mode_wt = 0;
  logic st_valid = 0, st_ready, st_err, busy;
  logic [31:0] st_addr = '0;
  logic [1:0] st_size = '0;
  logic [63:0] st_data = '0;
  logic ew_valid, ew_ready = 1, fr_valid, fr_ready = 1, fd_valid = 0, fd_ready;
  logic [31:0] ew_addr, fr_addr;
  logic [2:0] ew_size;
  logic [255:0] ew_data, fd_data = '0;

  int checks = 0, errors = 0, ew_cnt = 0, fr_cnt = 0, fr_served = 0;
  logic [31:0] ew_log_addr, fr_log_addr;
  logic [2:0] ew_log_size;
  logic [255:0] ew_log_data;

  always #2 clk = ~clk;

  wcache_store_ctrl i_wcache_store_ctrl (
    .clk, .rst_n, .mode_wt, .st_valid, .st_ready, .st_addr, .st_size, .st_data,
    .st_err, .busy, .ew_valid, .ew_ready, .ew_addr, .ew_size, .ew_data,
    .fr_valid, .fr_ready, .fr_addr, .fd_valid, .fd_ready, .fd_data
  );

  always @(posedge clk) begin
    if (ew_valid && ew_ready) begin
      ew_cnt++; ew_log_addr = ew_addr; ew_log_size = ew_size; ew_log_data = ew_data;
    end
    if (fr_valid && fr_ready) begin
      fr_cnt++; fr_log_addr = fr_addr;
    end
  end

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] pat(input int k);
    logic [255:0] p;
    for (int i = 0; i < 32; i++) p[8*i +: 8] = 8'(k*40 + i);
    return p;
  endfunction

  function automatic logic [255:0] setb(input logic [255:0] l, input int i, input logic [7:0] v);
    l[8*i +: 8] = v;
    return l;
  endfunction

  task automatic store(input logic [31:0] a, input logic [1:0] s, input logic [63:0] d);
    @(negedge clk);
    st_valid = 1; st_addr = a; st_size = s; st_data = d;
    while (!st_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    st_valid = 0;
  endtask

  task automatic wait_idle();
    for (int n = 0; busy && n < 100; n++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic serve_fill(input logic [31:0] exp_addr, input int k, input int hold);
    int e0;
    for (int n = 0; fr_cnt <= fr_served && n < 100; n++) @(negedge clk);
    fr_served++;
    chk("R5 fill request seen", 256'(fr_cnt), 256'(fr_served));
    chk("R5 fill address", 256'(fr_log_addr), 256'(exp_addr));
    e0 = ew_cnt;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R7 no write-back before fill", 256'(ew_cnt), 256'(e0));
      chk("R9 stalled during fill", {busy, st_ready}, 256'(2'b10));
    end
    while (!fd_ready) @(negedge clk);
    fd_valid = 1; fd_data = pat(k);
    @(posedge clk);
    @(negedge clk);
    fd_valid = 0;
  endtask

  task automatic t_reset();
    chk("R10 reset outputs", {busy, st_ready, ew_valid, fr_valid, st_err}, 256'(5'b01000));
  endtask

  task automatic t_cb_miss_clean();
    int e0 = ew_cnt;
    mode_wt = 0;
    store(32'h0001_0124, 2'd2, 64'h1122_3344);
    chk("R9 busy after miss", {busy, st_ready}, 256'(2'b10));
    serve_fill(32'h0001_0124, 1, 2);
    wait_idle();
    chk("R5 clean victim no write", 256'(ew_cnt), 256'(e0));
  endtask

  task automatic t_cb_hit();
    int e0 = ew_cnt, f0 = fr_cnt;
    store(32'h0001_0125, 2'd0, 64'h5A);
    chk("R2 hit no stall", {busy, st_ready}, 256'(2'b01));
    repeat (3) @(negedge clk);
    chk("R2 hit no traffic", {ew_cnt[7:0], fr_cnt[7:0]}, {e0[7:0], f0[7:0]});
  endtask

  task automatic t_dirty_evict();
    logic [255:0] exp = pat(1);
    int e0 = ew_cnt;
    exp = setb(exp, 4, 8'h44); exp = setb(exp, 5, 8'h5A);
    exp = setb(exp, 6, 8'h22); exp = setb(exp, 7, 8'h11);
    store(32'h0002_0120, 2'd3, 64'h0102_0304_0506_0708);
    serve_fill(32'h0002_0120, 2, 3);
    wait_idle();
    chk("R7 one write-back", 256'(ew_cnt), 256'(e0 + 1));
    chk("R7 victim address", 256'(ew_log_addr), 256'(32'h0001_0120));
    chk("R7 line size code", 256'(ew_log_size), 256'(3'd4));
    chk("R1 R6 victim data", ew_log_data, exp);
  endtask

  task automatic t_dirty_after_fill();
    logic [255:0] exp = pat(2);
    exp[63:0] = 64'h0102_0304_0506_0708;
    store(32'h0003_0120, 2'd0, 64'h77);
    serve_fill(32'h0003_0120, 3, 0);
    wait_idle();
    chk("R6 filled line is dirty", 256'(ew_log_addr), 256'(32'h0002_0120));
    chk("R6 merge keeps store bytes", ew_log_data, exp);
  endtask

  task automatic t_wt_hit();
    int e0 = ew_cnt, f0 = fr_cnt;
    mode_wt = 1;
    store(32'h0003_0122, 2'd1, 64'hBEEF);
    wait_idle();
    chk("R3 external write", 256'(ew_cnt), 256'(e0 + 1));
    chk("R3 address size", {ew_log_addr, ew_log_size}, {32'h0003_0122, 3'd1});
    chk("R3 data", ew_log_data, 256'hBEEF);
    chk("R3 no fill", 256'(fr_cnt), 256'(f0));
  endtask

  task automatic t_wt_miss();
    int e0 = ew_cnt, f0 = fr_cnt;
    mode_wt = 1;
    store(32'h0004_0240, 2'd2, 64'hCAFE_F00D);
    wait_idle();
    chk("R4 external write", 256'(ew_cnt), 256'(e0 + 1));
    chk("R4 address size", {ew_log_addr, ew_log_size}, {32'h0004_0240, 3'd2});
    chk("R4 data", ew_log_data, 256'hCAFE_F00D);
    chk("R4 no fill", 256'(fr_cnt), 256'(f0));
    mode_wt = 0;
    e0 = ew_cnt;
    store(32'h0004_0240, 2'd0, 64'h01);
    serve_fill(32'h0004_0240, 4, 0);
    wait_idle();
    chk("R4 cache left unchanged", 256'(fr_cnt), 256'(f0 + 1));
    chk("R5 invalid victim no write", 256'(ew_cnt), 256'(e0));
  endtask

  task automatic t_misaligned();
    int e0 = ew_cnt, f0 = fr_cnt;
    mode_wt = 0;
    store(32'h0003_0124, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R8 quad flag", {st_err, busy}, 256'(2'b10));
    @(negedge clk);
    chk("R8 flag one cycle", 256'(st_err), 256'(0));
    store(32'h0003_0122, 2'd2, 64'hFFFF_FFFF);
    chk("R8 long flag", 256'(st_err), 256'(1));
    store(32'h0003_0121, 2'd1, 64'hFFFF);
    chk("R8 word flag", 256'(st_err), 256'(1));
    store(32'h0003_0121, 2'd0, 64'hFF);
    chk("R8 byte never flagged", 256'(st_err), 256'(0));
    repeat (3) @(negedge clk);
    chk("R8 no traffic", {ew_cnt[7:0], fr_cnt[7:0]}, {e0[7:0], f0[7:0]});
  endtask

  task automatic t_line_content();
    logic [255:0] exp = pat(3);
    exp = setb(exp, 0, 8'h77); exp = setb(exp, 1, 8'hFF);
    exp = setb(exp, 2, 8'hEF); exp = setb(exp, 3, 8'hBE);
    store(32'h0005_0120, 2'd0, 64'h99);
    serve_fill(32'h0005_0120, 5, 0);
    wait_idle();
    chk("R1 evicted address", 256'(ew_log_addr), 256'(32'h0003_0120));
    chk("R3 R8 evicted content", ew_log_data, exp);
  endtask

  task automatic t_backpressure();
    logic [31:0] a0;
    int e0 = ew_cnt;
    mode_wt = 1;
    ew_ready = 0;
    store(32'h0005_0128, 2'd2, 64'h1234_5678);
    a0 = ew_addr;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 held write", {ew_valid, busy, st_ready, ew_addr}, {3'b110, a0});
    end
    chk("R9 held address", 256'(a0), 256'(32'h0005_0128));
    ew_ready = 1;
    wait_idle();
    chk("R9 write after release", 256'(ew_cnt), 256'(e0 + 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cb_miss_clean();
    t_cb_hit();
    t_dirty_evict();
    t_dirty_after_fill();
    t_wt_hit();
    t_wt_miss();
    t_misaligned();
    t_line_content();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R9 watchdog act=hung exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule